// File: doc/BRIEF.md
# Regulator Rail Enable Sequencer

This block drives the on/off enables for eight switchable regulator rails and one always-on real-time-clock rail. Each switchable rail belongs to one of two hardware enable groups. A rail turns on only when its group pin is active and its own software enable bit is set. The "system" group has one more condition: its pin counts only after the PMIC reset line and the battery fault line have both been released. The "power" group further requires the qualified system condition, unless a stored bypass bit removes that dependency.

The three external conditions arrive asynchronously. They pass through a common synchronizer of `SYNC_STAGES` flops, so every rail of a group changes in the same clock cycle. The per-rail software enable bits, the bypass bit and the converter clock-source bit are held in a small configuration register. That register loads on a single write strobe and resets to the pin-only behaviour, with every software bit set to 1. The stored clock-source bit is presented directly as the converter clock select.

Top module: `rail_enable_seq`

## Requirements
- R1: `rtc_on` is 1 at all times, including while `rst_n` is low.
- R2: While `rst_n` is low, `rail_en` is all zeros and `clk_sel_ext` is 0. After reset, every stored software bit is 1, so with all pins active every rail turns on without any configuration write.
- R3: A rail outside `PWR_GROUP_MASK` (default: bits 0,1,2,3,6,7 of `rail_en`) is on exactly when `sys_en_pin`, `reset_hold_n`, `batt_fault_n` and that rail's stored software bit are all 1.
- R4: A rail inside `PWR_GROUP_MASK` (default: bits 4 and 5) is on exactly when `pwr_en_pin` and its stored software bit are 1, and either the R3 system condition holds or the stored bypass bit is 1.
- R5: With the stored bypass bit at 1, the power-group rails follow `pwr_en_pin` and their software bits alone, even while `sys_en_pin`, `reset_hold_n` or `batt_fault_n` is low. The system-group rails are unaffected by the bypass bit.
- R6: While either `reset_hold_n` or `batt_fault_n` is 0, the system group stays off. Releasing the two lines in either order turns it on only once both are 1.
- R7: A change on any of the four condition pins reaches `rail_en` after exactly `SYNC_STAGES`+1 rising clock edges, and all rails of an affected group change in the same cycle.
- R8: The configuration inputs `cfg_rail_sw`, `cfg_bypass` and `cfg_clk_ext` are stored only on a rising edge where `cfg_wr` is 1. At any other time, changes to them have no effect on `rail_en` or `clk_sel_ext`.
- R9: `clk_sel_ext` shows the stored clock-source bit (0 = internal oscillator, 1 = external 13 MHz clock) from the edge that stores it. The bit does not influence `rail_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_en_pin | input | 1 | System group hardware enable, active high |
| pwr_en_pin | input | 1 | Power group hardware enable, active high |
| reset_hold_n | input | 1 | PMIC reset line, 1 = released |
| batt_fault_n | input | 1 | Battery fault line, 1 = no fault |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rail_sw | input | NUM_RAILS | Per-rail software enable bits to store |
| cfg_bypass | input | 1 | Bypass bit to store: 1 frees the power group from the system condition |
| cfg_clk_ext | input | 1 | Clock-source bit to store |
| rail_en | output | NUM_RAILS | Per-rail regulator enable |
| rtc_on | output | 1 | Real-time-clock rail enable, always 1 |
| clk_sel_ext | output | 1 | Converter clock select, 1 = external clock |

## Verification
The bench builds the block with its defaults: eight rails, a power-group mask of bits 4 and 5, and a two-stage synchronizer. Under these values the pin-to-rail latency is exactly three edges, and the bench can check it on both sides of the transition. The two-rail power group sits between system-group bits, so any bit-mapping mistake in the group decode shows up in the table of mixed software masks. The bench also drives the two release lines in both orders, and it changes the configuration inputs without a strobe.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

  // Synchronized condition pins, one struct so every stage moves them together.
  typedef struct packed {
    logic sys_pin;
    logic pwr_pin;
    logic rst_rel;
    logic flt_clr;
  } cond_vec_t;

  localparam int unsigned COND_W = $bits(cond_vec_t);

  // System condition: pin active and both hold-off lines released.
  function automatic logic sys_qualify(input logic pin, input logic rst_rel,
                                       input logic flt_clr);
    return pin & rst_rel & flt_clr;
  endfunction

  // Power condition: pin active and either system condition or bypass.
  function automatic logic pwr_qualify(input logic pin, input logic sys_ok,
                                       input logic bypass);
    return pin & (sys_ok | bypass);
  endfunction

  // One rail: its software bit and the condition of the group it sits in.
  function automatic logic rail_gate(input logic sw_bit, input logic in_pwr,
                                     input logic sys_ok, input logic pwr_ok);
    return sw_bit & (in_pwr ? pwr_ok : sys_ok);
  endfunction

endpackage

// File: rtl/rseq_sync.sv
module rseq_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/rseq_cfg.sv
module rseq_cfg #(
  parameter int unsigned NUM_RAILS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [NUM_RAILS-1:0] sw_in,
  input  logic                 byp_in,
  input  logic                 clk_in,
  output logic [NUM_RAILS-1:0] sw_q,
  output logic                 byp_q,
  output logic                 clk_q
);
  // Software bits reset to ones: pins alone decide after reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q  <= '1;
      byp_q <= 1'b0;
      clk_q <= 1'b0;
    end else if (wr) begin
      sw_q  <= sw_in;
      byp_q <= byp_in;
      clk_q <= clk_in;
    end
  end
endmodule

// File: rtl/rseq_gate.sv
module rseq_gate
  import rail_seq_pkg::*;
#(
  parameter int unsigned               NUM_RAILS      = 8,
  parameter logic [NUM_RAILS-1:0]      PWR_GROUP_MASK = 'h30
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  cond_vec_t            cond,
  input  logic [NUM_RAILS-1:0] sw_q,
  input  logic                 byp_q,
  output logic                 sys_ok,
  output logic                 pwr_ok,
  output logic [NUM_RAILS-1:0] rail_en
);
  logic [NUM_RAILS-1:0] rail_nxt;

  assign sys_ok = sys_qualify(cond.sys_pin, cond.rst_rel, cond.flt_clr);
  assign pwr_ok = pwr_qualify(cond.pwr_pin, sys_ok, byp_q);

  for (genvar g = 0; g < int'(NUM_RAILS); g++) begin : g_rail
    assign rail_nxt[g] = rail_gate(sw_q[g], PWR_GROUP_MASK[g], sys_ok, pwr_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rail_en <= '0;
    else        rail_en <= rail_nxt;
  end
endmodule

// File: rtl/rail_enable_seq.sv
module rail_enable_seq
  import rail_seq_pkg::*;
#(
  parameter int unsigned          NUM_RAILS      = 8,
  parameter int unsigned          SYNC_STAGES    = 2,
  parameter logic [NUM_RAILS-1:0] PWR_GROUP_MASK = 'h30
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sys_en_pin,
  input  logic                 pwr_en_pin,
  input  logic                 reset_hold_n,
  input  logic                 batt_fault_n,
  input  logic                 cfg_wr,
  input  logic [NUM_RAILS-1:0] cfg_rail_sw,
  input  logic                 cfg_bypass,
  input  logic                 cfg_clk_ext,
  output logic [NUM_RAILS-1:0] rail_en,
  output logic                 rtc_on,
  output logic                 clk_sel_ext
);
  cond_vec_t            cond_raw;
  logic [COND_W-1:0]    cond_bits;
  cond_vec_t            cond_s;
  logic [NUM_RAILS-1:0] sw_q;
  logic                 byp_q;
  logic                 sys_gate;
  logic                 pwr_gate;

  assign cond_raw = '{sys_pin: sys_en_pin, pwr_pin: pwr_en_pin,
                      rst_rel: reset_hold_n, flt_clr: batt_fault_n};

  rseq_sync #(.WIDTH(COND_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(cond_raw), .q(cond_bits)
  );
  assign cond_s = cond_vec_t'(cond_bits);

  rseq_cfg #(.NUM_RAILS(NUM_RAILS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .sw_in(cfg_rail_sw),
    .byp_in(cfg_bypass), .clk_in(cfg_clk_ext),
    .sw_q(sw_q), .byp_q(byp_q), .clk_q(clk_sel_ext)
  );

  rseq_gate #(.NUM_RAILS(NUM_RAILS), .PWR_GROUP_MASK(PWR_GROUP_MASK)) u_gate (
    .clk(clk), .rst_n(rst_n), .cond(cond_s), .sw_q(sw_q), .byp_q(byp_q),
    .sys_ok(sys_gate), .pwr_ok(pwr_gate), .rail_en(rail_en)
  );

  assign rtc_on = 1'b1;
endmodule

// File: rtl/rail_enable_seq_chk.sv
module rail_enable_seq_chk #(
  parameter int unsigned          NUM_RAILS      = 8,
  parameter logic [NUM_RAILS-1:0] PWR_GROUP_MASK = 'h30
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sys_gate,
  input logic                 pwr_gate,
  input logic                 byp_q,
  input logic                 cfg_wr,
  input logic                 cfg_clk_ext,
  input logic [NUM_RAILS-1:0] rail_en,
  input logic                 clk_sel_ext
);
  localparam logic [NUM_RAILS-1:0] SYS_MASK = ~PWR_GROUP_MASK;

  // R3
  sys_rail_needs_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rail_en & SYS_MASK) != '0) |-> $past(sys_gate));

  // R4
  pwr_rail_needs_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rail_en & PWR_GROUP_MASK) != '0) |-> $past(pwr_gate));

  // R5
  pwr_rail_no_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((rail_en & PWR_GROUP_MASK) != '0) && !$past(byp_q)) |-> $past(sys_gate));

  // R7
  sys_group_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_gate |=> ((rail_en & SYS_MASK) == '0));

  // R7
  pwr_group_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_gate |=> ((rail_en & PWR_GROUP_MASK) == '0));

  // R8
  clk_sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(clk_sel_ext));

  // R9
  clk_sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (clk_sel_ext == $past(cfg_clk_ext)));
endmodule

bind rail_enable_seq rail_enable_seq_chk #(
  .NUM_RAILS(NUM_RAILS), .PWR_GROUP_MASK(PWR_GROUP_MASK)
) i_chk (
  .clk(clk), .rst_n(rst_n), .sys_gate(sys_gate), .pwr_gate(pwr_gate),
  .byp_q(byp_q), .cfg_wr(cfg_wr), .cfg_clk_ext(cfg_clk_ext),
  .rail_en(rail_en), .clk_sel_ext(clk_sel_ext)
);

// File: tb/test_rail_enable_seq.sv
module test_rail_enable_seq;
  localparam int unsigned NR  = 8;
  localparam int unsigned SS  = 2;
  localparam int unsigned LAT = SS + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sys_en_pin = 1'b1, pwr_en_pin = 1'b1;
  logic          reset_hold_n = 1'b1, batt_fault_n = 1'b1;
  logic          cfg_wr = 1'b0, cfg_bypass = 1'b0, cfg_clk_ext = 1'b0;
  logic [NR-1:0] cfg_rail_sw = '0;
  logic [NR-1:0] rail_en;
  logic          rtc_on, clk_sel_ext;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  rail_enable_seq #(.NUM_RAILS(NR), .SYNC_STAGES(SS), .PWR_GROUP_MASK(8'h30))
    i_rail_enable_seq (
      .clk(clk), .rst_n(rst_n), .sys_en_pin(sys_en_pin), .pwr_en_pin(pwr_en_pin),
      .reset_hold_n(reset_hold_n), .batt_fault_n(batt_fault_n), .cfg_wr(cfg_wr),
      .cfg_rail_sw(cfg_rail_sw), .cfg_bypass(cfg_bypass), .cfg_clk_ext(cfg_clk_ext),
      .rail_en(rail_en), .rtc_on(rtc_on), .clk_sel_ext(clk_sel_ext));

  // Row: {sys, pwr, rst_rel, flt_clr, bypass, sw[7:0], expected[7:0]}
  localparam int NV = 10;
  localparam logic [20:0] VEC [NV] = '{
    {5'b11110, 8'hFF, 8'hFF},
    {5'b10110, 8'hFF, 8'hCF},
    {5'b01110, 8'hFF, 8'h00},
    {5'b01111, 8'hFF, 8'h30},
    {5'b11010, 8'hFF, 8'h00},
    {5'b11101, 8'hFF, 8'h30},
    {5'b11110, 8'hA5, 8'hA5},
    {5'b10110, 8'h5A, 8'h4A},
    {5'b00111, 8'hFF, 8'h00},
    {5'b11111, 8'h3C, 8'h3C}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [NR-1:0] sw, input logic byp, input logic ck);
    @(negedge clk);
    cfg_rail_sw = sw; cfg_bypass = byp; cfg_clk_ext = ck; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic set_pins(input logic s, input logic p, input logic r, input logic f);
    @(negedge clk);
    sys_en_pin = s; pwr_en_pin = p; reset_hold_n = r; batt_fault_n = f;
  endtask

  task automatic settle();
    repeat (LAT) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R1 R2: reset state with every pin active
    repeat (4) @(negedge clk);
    check("R2 rail_en in reset", 32'(rail_en), 32'h0);
    check("R2 clk_sel_ext in reset", 32'(clk_sel_ext), 32'h0);
    check("R1 rtc_on in reset", 32'(rtc_on), 32'h1);
    rst_n = 1'b1;
    settle();
    check("R2 default sw bits all on", 32'(rail_en), 32'hFF);
    check("R1 rtc_on after reset", 32'(rtc_on), 32'h1);

    // R3 R4 R5 R6: table of conditions and masks
    for (int i = 0; i < NV; i++) begin
      cfg_write(VEC[i][15:8], VEC[i][16], 1'b0);
      set_pins(VEC[i][20], VEC[i][19], VEC[i][18], VEC[i][17]);
      settle();
      check($sformatf("R3 R4 R5 R6 table row %0d", i), 32'(rail_en), 32'(VEC[i][7:0]));
    end

    // R6: release order, reset line first
    cfg_write(8'hFF, 1'b0, 1'b0);
    set_pins(1, 1, 0, 0); settle();
    check("R6 both held", 32'(rail_en), 32'h00);
    set_pins(1, 1, 1, 0); settle();
    check("R6 reset released fault held", 32'(rail_en), 32'h00);
    set_pins(1, 1, 1, 1); settle();
    check("R6 both released order A", 32'(rail_en), 32'hFF);
    // R6: fault line first
    set_pins(1, 1, 0, 0); settle();
    set_pins(1, 1, 0, 1); settle();
    check("R6 fault cleared reset held", 32'(rail_en), 32'h00);
    set_pins(1, 1, 1, 1); settle();
    check("R6 both released order B", 32'(rail_en), 32'hFF);

    // R7: exact latency and group drop in one cycle
    set_pins(0, 1, 1, 1);
    repeat (LAT - 1) @(posedge clk);
    @(negedge clk);
    check("R7 before latency", 32'(rail_en), 32'hFF);
    @(posedge clk); @(negedge clk);
    check("R7 all rails drop together", 32'(rail_en), 32'h00);
    set_pins(1, 1, 1, 1);
    repeat (LAT - 1) @(posedge clk);
    @(negedge clk);
    check("R7 rise before latency", 32'(rail_en), 32'h00);
    @(posedge clk); @(negedge clk);
    check("R7 rise at latency", 32'(rail_en), 32'hFF);

    // R8: configuration inputs without strobe are ignored
    @(negedge clk);
    cfg_rail_sw = 8'h00; cfg_bypass = 1'b1; cfg_clk_ext = 1'b1;
    settle();
    check("R8 sw bits unchanged without strobe", 32'(rail_en), 32'hFF);
    check("R8 clk select unchanged without strobe", 32'(clk_sel_ext), 32'h0);
    set_pins(0, 1, 1, 1); settle();
    check("R8 bypass not stored without strobe", 32'(rail_en), 32'h00);
    set_pins(1, 1, 1, 1); settle();

    // R9: clock-source select
    cfg_write(8'hFF, 1'b0, 1'b1);
    check("R9 external clock selected", 32'(clk_sel_ext), 32'h1);
    settle();
    check("R9 rails unaffected by clock bit", 32'(rail_en), 32'hFF);
    cfg_write(8'hFF, 1'b0, 1'b0);
    check("R9 internal clock selected", 32'(clk_sel_ext), 32'h0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule